// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block routes byte channels between framed TDM streams without blocking. In each frame, every channel that arrives on any input stream is stored in a data memory. A connection table, indexed by output stream and channel, then decides what each output channel sends. It can send a byte taken from any input stream and channel, a fixed byte held in the table, or nothing at all, in which case the output is held at high impedance. Because the table may name the same source many times, one input channel can be broadcast to many outputs.

The interface works at the byte level, after the serial streams have been deserialized. An input byte arrives with its stream and channel index. An output channel is fetched by presenting its stream and channel index, and the result comes back one cycle later with an output-enable flag. A frame-start strobe marks each frame boundary. At that strobe the two data-memory banks swap roles, and the table settings written during the previous frame become active. A frame therefore never mixes old and new routing. Each output channel picks its own delay. Constant delay always replays the previous frame, which keeps a frame intact. Minimum delay takes the current frame's byte when that source channel comes earlier in the frame than the output channel.

Top module: `tsi_switch`

## Requirements
- R1: After reset, and until a table write with the enable bit set has been committed by a frame-start strobe, every output response has out_oe=0 and out_data=0.
- R2: A request (out_req=1 with out_stream/out_chan) gives out_valid=1 with its result on the following cycle. A cycle without a request gives out_valid=0 on the following cycle.
- R3: Table entry layout (13 bits at 16 streams x 64 channels): bit 12 selects minimum delay, bit 11 enables the output, bit 10 selects message mode, bits 9:6 hold the source stream and bits 5:0 the source channel. The table address and the data address are both stream*CHANS+channel.
- R4: With the enable bit set and constant delay selected, an output channel sends the byte that its source stream and channel received during the previous frame.
- R5: With minimum delay selected and the source channel number lower than the output channel number, the output sends the byte that its source received earlier in the current frame.
- R6: With minimum delay selected and the source channel number equal to or higher than the output channel number, the output sends the source's byte from the previous frame.
- R7: With the enable bit and message mode both set, the output sends bits 7:0 of its table entry, whatever the input data.
- R8: With the enable bit clear, the output gives out_oe=0 and out_data=0, even when message mode is set.
- R9: Table writes take effect only at the next frame-start strobe. Outputs fetched in the same frame as the write still follow the previous settings.
- R10: Several output channels that name the same source all send that source's byte in the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame boundary strobe: swaps the banks and commits table writes |
| in_valid | input | 1 | Input byte present |
| in_stream | input | 4 | Input stream index |
| in_chan | input | 6 | Input channel index within the frame |
| in_data | input | 8 | Input channel byte |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 10 | Output channel entry to write (stream*CHANS+channel) |
| cfg_wdata | input | 13 | Entry value, layout as in R3 |
| out_req | input | 1 | Output channel fetch request |
| out_stream | input | 4 | Requested output stream |
| out_chan | input | 6 | Requested output channel |
| out_valid | output | 1 | Result of the previous cycle's request is present |
| out_data | output | 8 | Output channel byte (0 when disabled) |
| out_oe | output | 1 | Output drive enable; 0 means high impedance |

## Verification
The assertions assume that frame_start arrives on a cycle of its own, with no table write, input byte or fetch in that cycle. They also assume that, within a frame, each channel slot is written before the outputs of the same slot are fetched. The stimulus follows this order. It pulses the strobe alone, writes any new table contents right after the strobe, and then, slot by slot, writes all sixteen input streams before fetching all sixteen outputs. Input bytes and several of the tables are drawn from $urandom with a fixed seed. The remaining tables are directed, covering broadcast and source channels just below, equal to and just above the output channel.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int STREAMS = 16,
  parameter int CHANS   = 64,
  localparam int SW = $clog2(STREAMS),
  localparam int CW = $clog2(CHANS),
  localparam int AW = SW + CW,
  localparam int EW = ((AW > 8) ? AW : 8) + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          in_valid,
  input  logic [SW-1:0] in_stream,
  input  logic [CW-1:0] in_chan,
  input  logic [7:0]    in_data,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [EW-1:0] cfg_wdata,
  input  logic          out_req,
  input  logic [SW-1:0] out_stream,
  input  logic [CW-1:0] out_chan,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_oe
);
  localparam int NCH   = 1 << AW;
  localparam int B_VAR = EW - 1;
  localparam int B_OE  = EW - 2;
  localparam int B_MSG = EW - 3;

  logic [7:0]    dmem   [2][NCH];
  logic [EW-1:0] cm_new [NCH];
  logic [EW-1:0] cm_act [NCH];
  logic          wbank;

  logic [EW-1:0] entry;
  logic [AW-1:0] src;
  logic          same_frame;
  logic [7:0]    sel_byte;

  assign entry      = cm_act[{out_stream, out_chan}];
  assign src        = entry[AW-1:0];
  assign same_frame = entry[B_VAR] && (entry[CW-1:0] < out_chan);
  assign sel_byte   = entry[B_MSG] ? entry[7:0]
                    : dmem[same_frame ? wbank : ~wbank][src];

  always_ff @(posedge clk) begin
    if (in_valid) dmem[wbank][{in_stream, in_chan}] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbank <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        cm_new[i] <= '0;
        cm_act[i] <= '0;
      end
    end else begin
      if (frame_start) begin
        wbank  <= ~wbank;
        cm_act <= cm_new;
      end
      if (cfg_we) cm_new[cfg_addr] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_oe    <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= out_req;
      out_oe    <= out_req && entry[B_OE];
      out_data  <= (out_req && entry[B_OE]) ? sel_byte : 8'h00;
    end
  end
endmodule

// File: rtl/tsi_switch_checker.sv
module tsi_switch_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       cfg_we,
  input logic       cfg_oe,
  input logic       out_req,
  input logic       out_valid,
  input logic       out_oe,
  input logic [7:0] out_data
);
  logic pend_oe, live_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_oe <= 1'b0;
      live_oe <= 1'b0;
    end else begin
      if (cfg_we && cfg_oe) pend_oe <= 1'b1;
      if (frame_start && pend_oe) live_oe <= 1'b1;
    end
  end

  p_disabled_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !live_oe |-> !out_oe);
  p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |=> out_valid);
  p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_req |=> !out_valid);
  p_hiz_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_oe |-> (out_data == 8'h00));
  p_oe_only_when_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_oe |-> out_valid);
endmodule

bind tsi_switch tsi_switch_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_start(frame_start),
  .cfg_we     (cfg_we),
  .cfg_oe     (cfg_wdata[EW-2]),
  .out_req    (out_req),
  .out_valid  (out_valid),
  .out_oe     (out_oe),
  .out_data   (out_data)
);

// File: tb/tb_tsi_switch.sv
module tb_tsi_switch;
  localparam int ST  = 16;
  localparam int CH  = 64;
  localparam int NCH = ST * CH;
  localparam int EW  = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, in_valid = 0, cfg_we = 0, out_req = 0;
  logic [3:0] in_stream = '0, out_stream = '0;
  logic [5:0] in_chan = '0, out_chan = '0;
  logic [7:0] in_data = '0;
  logic [9:0] cfg_addr = '0;
  logic [EW-1:0] cfg_wdata = '0;
  logic out_valid, out_oe;
  logic [7:0] out_data;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0]    cur [NCH];
  logic [7:0]    prv [NCH];
  logic [EW-1:0] shadow [NCH];
  logic [EW-1:0] act [NCH];

  always #2 clk = ~clk;

  tsi_switch dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .in_valid(in_valid), .in_stream(in_stream), .in_chan(in_chan), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_req(out_req), .out_stream(out_stream), .out_chan(out_chan),
    .out_valid(out_valid), .out_data(out_data), .out_oe(out_oe)
  );

  // R3 layout: {var, oe, msg, stream[3:0], chan[5:0]}
  function automatic logic [EW-1:0] pack(bit v, bit oe, bit msg, int s, int c);
    logic [3:0] s4 = 4'(s);
    logic [5:0] c6 = 6'(c);
    return {v, oe, msg, s4, c6};
  endfunction

  function automatic logic [8:0] expect_out(int d, int c);
    logic [EW-1:0] e = act[d];
    if (!e[11]) return 9'h000;
    if (e[10]) return {1'b1, e[7:0]};
    if (e[12] && int'(e[5:0]) < c) return {1'b1, cur[e[9:0]]};
    return {1'b1, prv[e[9:0]]};
  endfunction

  function automatic string mode_tag(int d, int c);
    logic [EW-1:0] e = act[d];
    if (!e[11]) return "R8";
    if (e[10]) return "R7";
    if (!e[12]) return "R4";
    return (int'(e[5:0]) < c) ? "R5" : "R6";
  endfunction

  task automatic check(bit ok, string tag, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  task automatic program_cfg(int kind);
    for (int d = 0; d < NCH; d++) begin
      int s = d / CH, c = d % CH;
      logic [EW-1:0] e;
      case (kind)
        0: e = pack(0, 1, 0, (s + 5) % ST, (c * 7 + 3) % CH);
        1: e = pack(c[0], 1, 0, 2, 7);
        2: e = EW'($urandom);
        default: begin
          int sc = (s % 3 == 0) ? (c + CH - 1) % CH : (s % 3 == 1) ? c : (c + 1) % CH;
          e = pack(1, 1, 0, (s + 1) % ST, sc);
        end
      endcase
      shadow[d] = e;
      @(negedge clk);
      cfg_we = 1; cfg_addr = 10'(d); cfg_wdata = e;
    end
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_frame(int kind, string ftag);
    @(negedge clk);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    for (int i = 0; i < NCH; i++) begin
      prv[i] = cur[i];
      act[i] = shadow[i];
    end
    if (kind >= 0) program_cfg(kind);
    for (int c = 0; c < CH; c++) begin
      for (int s = 0; s < ST; s++) begin
        logic [7:0] b = 8'($urandom);
        @(negedge clk);
        in_valid = 1; in_stream = 4'(s); in_chan = 6'(c); in_data = b;
        cur[s * CH + c] = b;
      end
      @(negedge clk);
      in_valid = 0;
      for (int s = 0; s < ST; s++) begin
        logic [8:0] ex;
        string tag;
        out_req = 1; out_stream = 4'(s); out_chan = 6'(c);
        @(negedge clk);
        out_req = 0;
        ex  = expect_out(s * CH + c, c);
        tag = (ftag.len() != 0) ? ftag : mode_tag(s * CH + c, c);
        check(out_valid && out_oe == ex[8] && out_data == ex[7:0], tag,
              {out_valid, out_oe, out_data}, {1'b1, ex});
      end
      @(negedge clk);
      check(!out_valid, "R2", out_valid, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      cur[i] = '0; prv[i] = '0; shadow[i] = '0; act[i] = '0;
    end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(!out_valid && !out_oe && out_data == 0, "R1", {out_valid, out_oe, out_data}, 0);
    rst_n = 1;
    run_frame(-1, "R1");
    run_frame(0, "R9");  // constant-delay permutation written, not yet live
    run_frame(1, "");    // broadcast written, permutation live (R4)
    run_frame(2, "R10"); // broadcast live
    run_frame(3, "");    // random entries live: R4..R8
    run_frame(-1, "");   // directed minimum-delay set live: R5, R6
    run_frame(2, "");
    run_frame(-1, "");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule